// File: doc/BRIEF.md
# Interrupt request priority controller

This block holds the interrupt state of one processor core: a set of pending request flags, a set of in-service flags and a set of trigger-mode flags, one bit of each per vector. Requests arrive with a vector number and a trigger type. The block works out which pending vector has the highest number and compares its priority class (vector bits [7:4]) against a processor priority. That priority is built from a task priority value written by the core and from the class of the highest vector still in service.

When a request is deliverable, the block presents its vector to the core. An acknowledge strobe moves that vector from pending to in service. An end-of-interrupt strobe retires the highest in-service vector and reports that vector together with whether it was level-triggered, so that an upstream source can re-arm a level line. Deliverability, the vector and the priority are registered outputs. Each one reflects the controller state one clock after that state changes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, pending, in-service and trigger-mode flags and the task priority are all zero, so dlv_valid_o, ppr_o and eoi_done_o read 0.
- R2: While enabled, a request for a vector of 16 or more whose pending flag is clear is accepted: req_accepted_o is 1 in the same cycle, the pending flag is set, and the trigger-mode flag is set for level (req_level_i=1) or cleared for edge (req_level_i=0).
- R3: A request for a vector whose pending flag is already set gives req_accepted_o=0 and changes neither the pending nor the trigger-mode flag of that vector.
- R4: Unless hw_en_i and sw_en_i are both 1, requests are not accepted and dlv_valid_o is 0.
- R5: Requests for vectors 0 to 15 are never accepted, and dlv_vec_o is always 16 or more while dlv_valid_o is 1.
- R6: dlv_vec_o is the highest-numbered pending vector, across all 32-bit flag words. Vector bits [7:5] pick the word and bits [4:0] pick the bit.
- R7: Let S be the highest in-service vector, or 0 when none is in service. If TPR[7:4] >= S[7:4], the processor priority ppr_o equals TPR[7:0]. Otherwise it equals {S[7:4],4'h0}.
- R8: dlv_valid_o is 1 only when a vector is pending and {vec[7:4],4'h0} is strictly greater than ppr_o. Equal classes block delivery.
- R9: ack_i while dlv_valid_o is 1 sets the in-service flag of dlv_vec_o and clears its pending flag. dlv_valid_o reads 0 in the following cycle and is re-evaluated in the cycle after that.
- R10: eoi_i with a vector in service clears the highest in-service flag. In the next cycle it gives a one-cycle eoi_done_o pulse, with eoi_vec_o set to that vector and eoi_level_o set to its trigger-mode flag, and that trigger-mode flag is cleared.
- R11: eoi_i with nothing in service has no effect: no eoi_done_o pulse and no change to ppr_o.
- R12: A write on tpr_wr_i replaces the task priority with tpr_data_i, and ppr_o is recomputed from it.
- R13: dlv_valid_o, dlv_vec_o and ppr_o change one clock after the state change that causes them, not in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en_i | input | 1 | Hardware enable |
| sw_en_i | input | 1 | Software enable |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accepted_o | output | 1 | Request taken this cycle |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_data_i | input | 8 | New task priority |
| ack_i | input | 1 | Core takes the presented vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| dlv_valid_o | output | 1 | An interrupt is deliverable |
| dlv_vec_o | output | 8 | Vector to deliver |
| ppr_o | output | 8 | Processor priority |
| eoi_done_o | output | 1 | One-cycle pulse after a retiring EOI |
| eoi_vec_o | output | 8 | Vector that was retired |
| eoi_level_o | output | 1 | Retired vector was level-triggered |

## Verification
The selection logic is exercised with three patterns: pending vectors in different flag words (0x30, 0x51, 0x90), two vectors in the same word (0x30 and 0x3F), and a lower vector arriving after a higher one. Together these separate word-level choice from bit-level choice, and show that the choice does not depend on arrival order. The priority gate is swept with task priorities below, equal to and above the pending class, and with nested in-service vectors whose class is sometimes above and sometimes below the task priority. This exposes both branches of the priority rule and the strict comparison. End-of-interrupt trigger reports are checked after an edge request, after a dropped duplicate level request, and after a fresh level request. This shows that the trigger flag follows only accepted requests.

// File: rtl/irq_prio_pkg.sv
// Shared constants for the interrupt priority controller.
// Assumes vectors are grouped into priority classes by their upper nibble.
package irq_prio_pkg;
    localparam int unsigned CLASS_W       = 4;
    localparam int unsigned DEF_NUM_VEC   = 256;
    localparam int unsigned DEF_WORD_BITS = 32;
    localparam int unsigned DEF_MIN_VEC   = 16;
endpackage

// File: rtl/irq_prio_find.sv
// Two-level priority encoder: picks the highest non-empty word, then the
// highest set bit inside that word. Purely combinational.
// Assumes NUM_BITS is a multiple of WORD_BITS, and at least two words.
module irq_prio_find #(
    parameter int unsigned NUM_BITS  = 256,
    parameter int unsigned WORD_BITS = 32,
    localparam int unsigned NUM_WORDS = NUM_BITS / WORD_BITS,
    localparam int unsigned WD_W      = $clog2(NUM_WORDS),
    localparam int unsigned WB_W      = $clog2(WORD_BITS),
    localparam int unsigned IDX_W     = WD_W + WB_W
) (
    input  logic [NUM_BITS-1:0] bits_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o
);
    logic [NUM_WORDS-1:0] word_any;
    logic [WD_W-1:0]      word_sel;
    logic [WORD_BITS-1:0] word_bits;
    logic [WB_W-1:0]      bit_sel;

    // One OR-reduction for each word.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_any[w] = |bits_i[w*WORD_BITS +: WORD_BITS];
    end

    // First level: the last non-empty word wins, which is the highest.
    always_comb begin
        word_sel = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) word_sel = WD_W'(w);
        end
    end

    assign word_bits = bits_i[word_sel*WORD_BITS +: WORD_BITS];

    // Second level: the highest set bit inside the chosen word.
    always_comb begin
        bit_sel = '0;
        for (int b = 0; b < WORD_BITS; b++) begin
            if (word_bits[b]) bit_sel = WB_W'(b);
        end
    end

    assign found_o = |word_any;
    assign idx_o   = {word_sel, bit_sel};
endmodule

// File: rtl/irq_ppr_derive.sv
// Processor priority: the task priority when its class is not below the
// in-service class, otherwise the in-service class with a zero low part.
// Combinational. Assumes VEC_W > CLASS_W.
module irq_ppr_derive
    import irq_prio_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_found_i,
    input  logic [VEC_W-1:0] isr_vec_i,
    output logic [VEC_W-1:0] ppr_o
);
    localparam int unsigned LOW_W = VEC_W - CLASS_W;

    logic [VEC_W-1:0] isrv;

    assign isrv = isr_found_i ? isr_vec_i : '0;

    // Pick between task priority and in-service class.
    always_comb begin
        if (tpr_i[VEC_W-1 -: CLASS_W] >= isrv[VEC_W-1 -: CLASS_W])
            ppr_o = tpr_i;
        else
            ppr_o = {isrv[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}};
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Interrupt request priority controller. Holds pending, in-service and
// trigger-mode flag sets, gates delivery against the processor priority,
// and moves vectors from pending to in service to retired on ack and EOI.
// Assumes one request, one ack and one EOI at most per cycle. Outputs are
// registered and lag the state by one cycle.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_VEC   = DEF_NUM_VEC,
    parameter int unsigned WORD_BITS = DEF_WORD_BITS,
    parameter int unsigned MIN_VEC   = DEF_MIN_VEC,
    localparam int unsigned VEC_W    = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en_i,
    input  logic             sw_en_i,
    input  logic             req_valid_i,
    input  logic [VEC_W-1:0] req_vec_i,
    input  logic             req_level_i,
    output logic             req_accepted_o,
    input  logic             tpr_wr_i,
    input  logic [VEC_W-1:0] tpr_data_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             dlv_valid_o,
    output logic [VEC_W-1:0] dlv_vec_o,
    output logic [VEC_W-1:0] ppr_o,
    output logic             eoi_done_o,
    output logic [VEC_W-1:0] eoi_vec_o,
    output logic             eoi_level_o
);
    localparam int unsigned LOW_W = VEC_W - CLASS_W;

    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
    logic [VEC_W-1:0]   tpr_q;

    logic               irr_found, isr_found;
    logic [VEC_W-1:0]   irr_idx, isr_idx;
    logic [VEC_W-1:0]   ppr_c;
    logic               enabled, deliv_c, ack_take, eoi_take;
    logic [NUM_VEC-1:0] req_oh, ack_oh, eoi_oh;

    logic               dlv_valid_q;
    logic [VEC_W-1:0]   dlv_vec_q, ppr_q, eoi_vec_q;
    logic               eoi_done_q, eoi_level_q;

    irq_prio_find #(.NUM_BITS(NUM_VEC), .WORD_BITS(WORD_BITS)) irr_find_i (
        .bits_i (irr_q),
        .found_o(irr_found),
        .idx_o  (irr_idx)
    );

    irq_prio_find #(.NUM_BITS(NUM_VEC), .WORD_BITS(WORD_BITS)) isr_find_i (
        .bits_i (isr_q),
        .found_o(isr_found),
        .idx_o  (isr_idx)
    );

    irq_ppr_derive #(.VEC_W(VEC_W)) ppr_i (
        .tpr_i      (tpr_q),
        .isr_found_i(isr_found),
        .isr_vec_i  (isr_idx),
        .ppr_o      (ppr_c)
    );

    assign enabled        = hw_en_i & sw_en_i;
    assign req_accepted_o = req_valid_i & enabled & (req_vec_i >= VEC_W'(MIN_VEC))
                            & ~irr_q[req_vec_i];
    assign ack_take       = ack_i & dlv_valid_q;
    assign eoi_take       = eoi_i & isr_found;

    assign req_oh = NUM_VEC'(1) << req_vec_i;
    assign ack_oh = NUM_VEC'(1) << dlv_vec_q;
    assign eoi_oh = NUM_VEC'(1) << isr_idx;

    // Delivery gate: class of the top request strictly above the priority.
    assign deliv_c = enabled & irr_found
                     & ({irr_idx[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}} > ppr_c);

    // Next-state flag sets. A request's trigger write wins over the EOI clear.
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (ack_take) begin
            irr_d = irr_d & ~ack_oh;
            isr_d = isr_d | ack_oh;
        end
        if (eoi_take) begin
            isr_d = isr_d & ~eoi_oh;
            tmr_d = tmr_d & ~eoi_oh;
        end
        if (req_accepted_o) begin
            irr_d = irr_d | req_oh;
            tmr_d = req_level_i ? (tmr_d | req_oh) : (tmr_d & ~req_oh);
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            if (tpr_wr_i) tpr_q <= tpr_data_i;
        end
    end

    // Registered outputs; a taken ack hides the old vector for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid_q <= 1'b0;
            dlv_vec_q   <= '0;
            ppr_q       <= '0;
            eoi_done_q  <= 1'b0;
            eoi_vec_q   <= '0;
            eoi_level_q <= 1'b0;
        end else begin
            dlv_valid_q <= deliv_c & ~ack_take;
            dlv_vec_q   <= irr_idx;
            ppr_q       <= ppr_c;
            eoi_done_q  <= eoi_take;
            if (eoi_take) begin
                eoi_vec_q   <= isr_idx;
                eoi_level_q <= tmr_q[isr_idx];
            end
        end
    end

    assign dlv_valid_o = dlv_valid_q;
    assign dlv_vec_o   = dlv_vec_q;
    assign ppr_o       = ppr_q;
    assign eoi_done_o  = eoi_done_q;
    assign eoi_vec_o   = eoi_vec_q;
    assign eoi_level_o = eoi_level_q;
endmodule

// File: rtl/irq_prio_chk.sv
// Protocol checker for irq_prio_ctrl, attached through bind. Observes
// ports and the internal flag sets; drives nothing.
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_VEC = DEF_NUM_VEC,
    parameter int unsigned MIN_VEC = DEF_MIN_VEC,
    localparam int unsigned VEC_W  = $clog2(NUM_VEC),
    localparam int unsigned LOW_W  = VEC_W - CLASS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hw_en,
    input logic               sw_en,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vec,
    input logic               req_accepted,
    input logic [NUM_VEC-1:0] irr,
    input logic [NUM_VEC-1:0] isr,
    input logic               ack,
    input logic               eoi,
    input logic               dlv_valid,
    input logic [VEC_W-1:0]   dlv_vec,
    input logic [VEC_W-1:0]   ppr,
    input logic               eoi_done
);
    AST_REQ_SETS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        req_accepted |=> irr[$past(req_vec)]); // R2
    AST_DUP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && irr[req_vec]) |-> !req_accepted); // R3
    AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en && sw_en) |-> !req_accepted); // R4
    AST_LOW_VEC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_vec < VEC_W'(MIN_VEC))) |-> !req_accepted); // R5
    AST_DLV_MIN_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_vec >= VEC_W'(MIN_VEC))); // R5
    AST_DLV_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ({dlv_vec[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}} > ppr)); // R8
    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && dlv_valid) |=> (isr[$past(dlv_vec)] && !irr[$past(dlv_vec)] && !dlv_valid)); // R9
    AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (isr == '0)) |=> !eoi_done); // R11
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_VEC(NUM_VEC), .MIN_VEC(MIN_VEC)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_en       (hw_en_i),
    .sw_en       (sw_en_i),
    .req_valid   (req_valid_i),
    .req_vec     (req_vec_i),
    .req_accepted(req_accepted_o),
    .irr         (irr_q),
    .isr         (isr_q),
    .ack         (ack_i),
    .eoi         (eoi_i),
    .dlv_valid   (dlv_valid_o),
    .dlv_vec     (dlv_vec_o),
    .ppr         (ppr_o),
    .eoi_done    (eoi_done_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
// Directed bench for irq_prio_ctrl: one task per scenario, each checks itself.
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0, sw_en = 1'b0;
    logic       req_valid = 1'b0, req_level = 1'b0;
    logic [7:0] req_vec = '0;
    logic       req_accepted;
    logic       tpr_wr = 1'b0;
    logic [7:0] tpr_data = '0;
    logic       ack = 1'b0, eoi = 1'b0;
    logic       dlv_valid, eoi_done, eoi_level;
    logic [7:0] dlv_vec, ppr, eoi_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .hw_en_i(hw_en), .sw_en_i(sw_en),
        .req_valid_i(req_valid), .req_vec_i(req_vec), .req_level_i(req_level),
        .req_accepted_o(req_accepted), .tpr_wr_i(tpr_wr), .tpr_data_i(tpr_data),
        .ack_i(ack), .eoi_i(eoi), .dlv_valid_o(dlv_valid), .dlv_vec_o(dlv_vec),
        .ppr_o(ppr), .eoi_done_o(eoi_done), .eoi_vec_o(eoi_vec),
        .eoi_level_o(eoi_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic send_req(input logic [7:0] v, input logic lvl, input logic exp_acc, input string tag);
        req_valid = 1'b1; req_vec = v; req_level = lvl;
        #1 chk(tag, req_accepted, exp_acc);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R9 valid drops after ack", dlv_valid, 0);
    endtask

    task automatic do_eoi(input logic exp_done, input logic [7:0] exp_vec, input logic exp_lvl, input string tag);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
        chk(tag, eoi_done, exp_done);
        if (exp_done) begin
            chk({tag, " vec"}, eoi_vec, exp_vec);
            chk({tag, " level"}, eoi_level, exp_lvl);
        end
    endtask

    task automatic write_tpr(input logic [7:0] t);
        tpr_wr = 1'b1; tpr_data = t;
        @(negedge clk);
        tpr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 dlv_valid", dlv_valid, 0);
        chk("R1 ppr", ppr, 0);
        chk("R1 eoi_done", eoi_done, 0);
    endtask

    task automatic t_accept_and_order();
        send_req(8'h30, 1'b0, 1'b1, "R2 accept 0x30");
        chk("R13 no same-cycle delivery", dlv_valid, 0);
        settle();
        chk("R6 single pending valid", dlv_valid, 1);
        chk("R6 single pending vec", dlv_vec, 8'h30);
        send_req(8'h30, 1'b1, 1'b0, "R3 duplicate dropped");
        settle();
        chk("R3 vec unchanged", dlv_vec, 8'h30);
        send_req(8'h51, 1'b1, 1'b1, "R2 accept 0x51");
        settle();
        chk("R6 higher word wins", dlv_vec, 8'h51);
        send_req(8'h3F, 1'b0, 1'b1, "R2 accept 0x3F");
        settle();
        chk("R6 later lower request", dlv_vec, 8'h51);
        send_req(8'h0A, 1'b0, 1'b0, "R5 low vector rejected");
        settle();
        chk("R5 vec unchanged", dlv_vec, 8'h51);
    endtask

    task automatic t_disable();
        sw_en = 1'b0;
        send_req(8'h70, 1'b0, 1'b0, "R4 sw disabled");
        chk("R4 no delivery while disabled", dlv_valid, 0);
        hw_en = 1'b0; sw_en = 1'b1;
        send_req(8'h70, 1'b0, 1'b0, "R4 hw disabled");
        hw_en = 1'b1;
        settle();
        chk("R4 re-enabled valid", dlv_valid, 1);
        chk("R4 ignored vector absent", dlv_vec, 8'h51);
    endtask

    task automatic t_ack_tpr_eoi();
        do_ack();
        settle();
        chk("R7 ppr from in-service", ppr, 8'h50);
        chk("R8 lower class blocked", dlv_valid, 0);
        write_tpr(8'h67);
        chk("R13 ppr lags tpr write", ppr, 8'h50);
        settle();
        chk("R12 ppr from new tpr", ppr, 8'h67);
        do_eoi(1'b1, 8'h51, 1'b1, "R10 eoi level vector");
        settle();
        chk("R10 eoi pulse ends", eoi_done, 0);
        chk("R7 ppr after eoi", ppr, 8'h67);
        chk("R8 blocked by tpr", dlv_valid, 0);
        write_tpr(8'h2F); settle();
        chk("R8 class above tpr valid", dlv_valid, 1);
        chk("R8 class above tpr vec", dlv_vec, 8'h3F);
        write_tpr(8'h30); settle();
        chk("R8 equal class blocked", dlv_valid, 0);
        write_tpr(8'h00); settle();
        chk("R8 tpr zero valid", dlv_valid, 1);
    endtask

    task automatic t_eoi_empty();
        do_eoi(1'b0, 8'h00, 1'b0, "R11 eoi with none in service");
        settle();
        chk("R11 ppr unchanged", ppr, 8'h00);
        chk("R11 pending untouched", dlv_vec, 8'h3F);
    endtask

    task automatic t_nested();
        do_ack(); settle();
        chk("R7 ppr 0x30", ppr, 8'h30);
        chk("R8 same class as in-service blocked", dlv_valid, 0);
        send_req(8'h90, 1'b0, 1'b1, "R2 accept 0x90");
        settle();
        chk("R6 nested vec", dlv_vec, 8'h90);
        do_ack(); settle();
        chk("R7 ppr 0x90", ppr, 8'h90);
        write_tpr(8'hA4); settle();
        chk("R7 tpr class above isr", ppr, 8'hA4);
        write_tpr(8'h85); settle();
        chk("R7 isr class above tpr", ppr, 8'h90);
        do_eoi(1'b1, 8'h90, 1'b0, "R10 eoi highest first");
        settle();
        chk("R7 ppr back to tpr", ppr, 8'h85);
        write_tpr(8'h00); settle();
        chk("R7 ppr from 0x3F", ppr, 8'h30);
        do_eoi(1'b1, 8'h3F, 1'b0, "R10 eoi 0x3F edge");
        settle();
        chk("R7 ppr empty", ppr, 8'h00);
        chk("R6 remaining vec", dlv_vec, 8'h30);
        do_ack(); settle();
        do_eoi(1'b1, 8'h30, 1'b0, "R3 dropped duplicate left edge");
        settle();
        chk("R6 nothing pending", dlv_valid, 0);
        send_req(8'h30, 1'b1, 1'b1, "R2 re-request level");
        settle();
        do_ack(); settle();
        do_eoi(1'b1, 8'h30, 1'b1, "R2 level flag recorded");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        hw_en = 1'b1; sw_en = 1'b1;
        settle();
        t_accept_and_order();
        t_disable();
        t_ack_tpr_eoi();
        t_eoi_empty();
        t_nested();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule